// File: doc/BRIEF.md
# Ethernet PHY LED Behaviour Controller

This block turns the live status of an Ethernet PHY into four LED drive signals. The status inputs are levels: link state, link speed, power-down, energy-efficient mode and several maintenance activities (auto-negotiation, analog self-test, cable diagnostics, test mode). Three single-cycle strobes report transmit, receive and collision events. For each LED, a small set of configuration bytes picks the conditions under which it lights steadily, blinks at a fast rate, blinks at a slow rate, or goes dark briefly on traffic.

Two blink rates are shared by all four LEDs. A global pair of registers sets both rates and three chip-wide conditions: a running-light scan, a condition that suppresses that scan, and a common blink. Software reaches the ten configuration registers through a plain synchronous write port with a combinational read path. Management bus framing and the PHY datapath are outside this block.

The LED outputs are combinational functions of registered state and the current status levels, so a level change is seen in the same cycle. Two named state machines hold the sequential behaviour.

The activity stretcher has one instance per LED and two states:
- `PULSE_IDLE` goes to `PULSE_HOLD` when a masked event arrives.
- `PULSE_HOLD` stays in `PULSE_HOLD` and reloads its window when a new masked event arrives.
- `PULSE_HOLD` goes back to `PULSE_IDLE` once the window is used up.

The scan sequencer has four states, `SCAN_L0` through `SCAN_L3`. While the scan is enabled it steps `SCAN_L0`→`SCAN_L1`→`SCAN_L2`→`SCAN_L3`→`SCAN_L0`, one step per base tick. From any state it returns to `SCAN_L0` whenever the scan is not enabled.

Top module: `phy_led_ctrl`

## Requirements
- R1: After reset the ten registers read back as follows. The global rate/inverse register is 0x00C5 and the global scan/blink register is 0x0067. LED0 high/low are 0x0070/0x0003, LED1 high/low are 0x0020/0x0000, LED2 high/low are 0x0040/0x0000, and LED3 high/low are 0x0040/0x0020. With all status inputs low, all LEDs are off.
- R2: The registers sit at 0x1E0..0x1E9 in this order: global rate/inverse, global scan/blink, then the high and low register of LED0, LED1, LED2 and LED3. A write is visible on read in the next cycle. Bits 15:8 always read zero. Bit 3 of 0x1E0 and bits 7 and 3 of 0x1E1 are reserved and read zero.
- R3: A read of any address outside 0x1E0..0x1E9 returns zero. A write to such an address changes no register.
- R4: Each LED high register holds two 4-bit selectors: steady-on in bits 7:4 and fast-blink in bits 3:0. link_speed is coded 0=10, 1=100, 2=1000, 3=none. The selector codes are: 0 never; 1..7 a link that is up at a matching speed, where bit 0 matches 10, bit 1 matches 100 and bit 2 matches 1000; 8 power-down; 9 energy-efficient; 10 auto-negotiation; 11 self-test; 12 cable diagnostics; 13..15 never.
- R5: A base tick occurs every TICK_CYCLES clocks and advances a 4-bit rate counter that starts at zero after reset. Fast rate code c (0x1E0 bits 7:6) gives a wave equal to bit 3-c of that counter: 00=2 Hz, 01=4 Hz, 10=8 Hz, 11=16 Hz at nominal clock. When the fast-blink selector is true, the LED follows the fast wave.
- R6: The slow rate code (0x1E0 bits 5:4) selects the slow wave in the same way. The slow-blink selector sits in LED low register bits 7:4 and uses the R4 codes.
- R7: A lit decision follows this priority: fast-blink selector true gives the fast wave; otherwise slow-blink selector true gives the slow wave; otherwise the steady-on selector gives on or off.
- R8: The pulse mask is LED low register bits 2:0 (bit 0 transmit, bit 1 receive, bit 2 collision); bit 3 is ignored. A masked strobe sampled at a rising edge forces that LED dark for the next STRETCH_CYCLES cycles. Strobes that are not masked have no effect.
- R9: A masked strobe during a dark window restarts the window at its full length.
- R10: The complex blink condition is 0x1E1 bits 2:0, coded 0 none, 1 link up, 2 power-down, 3 energy-efficient, 4 auto-negotiation, 5 self-test, 6 cable diagnostics, 7 test mode. While it is true and the scan is not enabled, all four LEDs follow the fast wave, overriding per-LED settings.
- R11: The scan is enabled when the scan condition (0x1E1 bits 6:4, R10 codes) is true and the inverse condition is false. While the scan is enabled, exactly one LED is lit. The lit LED starts at LED0 and moves to the next higher index, wrapping, at each base tick. Scan overrides everything else.
- R12: When the inverse condition (0x1E0 bits 2:0, R10 codes) is true, the scan is suppressed and the LEDs fall back to the complex blink or per-LED behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_speed | input | 2 | Link speed: 0=10, 1=100, 2=1000, 3=none |
| link_up | input | 1 | Link established |
| pwr_down | input | 1 | PHY powered down |
| eee_mode | input | 1 | Energy-efficient mode active |
| aneg_busy | input | 1 | Auto-negotiation running |
| selftest_busy | input | 1 | Analog self-test running |
| cdiag_busy | input | 1 | Cable diagnostics running |
| test_mode | input | 1 | Test mode active |
| tx_evt | input | 1 | Single-cycle transmit event |
| rx_evt | input | 1 | Single-cycle receive event |
| col_evt | input | 1 | Single-cycle collision event |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 9 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| led | output | 4 | LED drive, 1 = lit |

## Verification
Status levels and register reads act in the same cycle, so the bench compares them at the falling edge that follows the change. A register write, an event strobe or a base tick acts through a register. Its effect is therefore due at the first falling edge after the rising edge that sampled it, and a dark window lasts exactly STRETCH_CYCLES such falling edges. The bench keeps its own rate counter, window counters, scan position and shadow registers, updated on each rising edge. It compares the LED outputs against this model at every falling edge, so each result is checked in the cycle it is due, under both directed corner cases and seeded random stimulus.

// File: rtl/phy_led_pkg.sv
package phy_led_pkg;
    localparam int NUM_LEDS = 4;
    localparam int NUM_REGS = 2 + 2 * NUM_LEDS;
    localparam int CFG_W    = 8;

    typedef enum logic [1:0] {
        SPD_10M  = 2'd0,
        SPD_100M = 2'd1,
        SPD_1G   = 2'd2,
        SPD_NONE = 2'd3
    } link_speed_e;

    typedef struct packed {
        logic [1:0] speed;
        logic       link_up;
        logic       pwr_down;
        logic       eee;
        logic       aneg;
        logic       selftest;
        logic       cdiag;
        logic       test;
    } phy_status_t;

    // Per-LED selector: codes 1..7 are a speed set, 8..12 a status, others never.
    function automatic logic led_cond(input logic [3:0] code, input phy_status_t s);
        logic lk10, lk100, lk1g;
        lk10  = s.link_up && (s.speed == SPD_10M);
        lk100 = s.link_up && (s.speed == SPD_100M);
        lk1g  = s.link_up && (s.speed == SPD_1G);
        if (!code[3])
            return (code[0] && lk10) || (code[1] && lk100) || (code[2] && lk1g);
        case (code[2:0])
            3'd0:    return s.pwr_down;
            3'd1:    return s.eee;
            3'd2:    return s.aneg;
            3'd3:    return s.selftest;
            3'd4:    return s.cdiag;
            default: return 1'b0;
        endcase
    endfunction

    // Global 3-bit condition used by scan, inverse scan and complex blink.
    function automatic logic cplx_cond(input logic [2:0] code, input phy_status_t s);
        case (code)
            3'd1:    return s.link_up;
            3'd2:    return s.pwr_down;
            3'd3:    return s.eee;
            3'd4:    return s.aneg;
            3'd5:    return s.selftest;
            3'd6:    return s.cdiag;
            3'd7:    return s.test;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [CFG_W-1:0] reg_reset(input int idx);
        case (idx)
            0:       return 8'hC5;
            1:       return 8'h67;
            2:       return 8'h70;
            3:       return 8'h03;
            4:       return 8'h20;
            6:       return 8'h40;
            8:       return 8'h40;
            9:       return 8'h20;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [CFG_W-1:0] reg_wmask(input int idx);
        case (idx)
            0:       return 8'hF7;
            1:       return 8'h77;
            default: return 8'hFF;
        endcase
    endfunction
endpackage

// File: rtl/phy_led_regs.sv
module phy_led_regs
    import phy_led_pkg::*;
#(
    parameter int              ADDR_W    = 9,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 'h1E0
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_we,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [15:0]                      reg_wdata,
    output logic [15:0]                      reg_rdata,
    output logic [NUM_REGS-1:0][CFG_W-1:0]   cfg_q
);
    localparam int BASE_I = int'(BASE_ADDR);

    int   offs;
    logic in_range;
    logic unused_wdata_hi;

    assign offs            = int'(reg_addr) - BASE_I;
    assign in_range        = (offs >= 0) && (offs < NUM_REGS);
    assign unused_wdata_hi = ^reg_wdata[15:CFG_W];

    always_ff @(posedge clk) begin
        for (int r = 0; r < NUM_REGS; r++) begin
            if (!rst_n)
                cfg_q[r] <= reg_reset(r);
            else if (reg_we && (offs == r))
                cfg_q[r] <= reg_wdata[CFG_W-1:0] & reg_wmask(r);
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int r = 0; r < NUM_REGS; r++)
            if (offs == r) reg_rdata = {{(16-CFG_W){1'b0}}, cfg_q[r]};
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_wchk
            // R2: a mapped write lands with reserved bits cleared
            assert_wr_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (reg_we && offs == g) |=> (cfg_q[g] == ($past(reg_wdata[CFG_W-1:0]) & reg_wmask(g))));
        end
    endgenerate

    // R3: an unmapped write leaves every register untouched
    assert_unmapped_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !in_range) |=> $stable(cfg_q));
endmodule

// File: rtl/phy_led_blink.sv
module phy_led_blink #(
    parameter int TICK_CYCLES = 1_562_500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] fast_code,
    input  logic [1:0] slow_code,
    output logic       tick,
    output logic       fast_wave,
    output logic       slow_wave
);
    localparam int                PRE_W    = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST = PRE_W'(TICK_CYCLES - 1);
    localparam int                RATE_W   = 4;

    logic [PRE_W-1:0]  pre_q;
    logic [RATE_W-1:0] rate_q;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            rate_q <= '0;
        end else if (tick) begin
            pre_q  <= '0;
            rate_q <= rate_q + RATE_W'(1);
        end else begin
            pre_q  <= pre_q + PRE_W'(1);
        end
    end

    // Code 3 picks bit 0 (fastest), code 0 picks bit 3 (slowest).
    assign fast_wave = rate_q[2'd3 - fast_code];
    assign slow_wave = rate_q[2'd3 - slow_code];

    // R5/R6: the rate counter only moves on a base tick
    assert_rate_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(rate_q));
endmodule

// File: rtl/phy_led_scan.sv
module phy_led_scan
    import phy_led_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                active,
    input  logic                tick,
    output logic [NUM_LEDS-1:0] scan_led
);
    typedef enum logic [1:0] {SCAN_L0, SCAN_L1, SCAN_L2, SCAN_L3} scan_state_e;

    scan_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCAN_L0;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!active)
            state_d = SCAN_L0;
        else if (tick) begin
            unique case (state_q)
                SCAN_L0: state_d = SCAN_L1;
                SCAN_L1: state_d = SCAN_L2;
                SCAN_L2: state_d = SCAN_L3;
                SCAN_L3: state_d = SCAN_L0;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            SCAN_L0: scan_led = 4'b0001;
            SCAN_L1: scan_led = 4'b0010;
            SCAN_L2: scan_led = 4'b0100;
            SCAN_L3: scan_led = 4'b1000;
        endcase
    end

    // R11: a tick while scanning rotates the lit position one place up
    assert_scan_rotate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick) |=> (scan_led == $past({scan_led[2:0], scan_led[3]})));
    // R11: leaving the scan always restarts from LED0
    assert_scan_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (scan_led == 4'b0001));
endmodule

// File: rtl/phy_led_lane.sv
module phy_led_lane
    import phy_led_pkg::*;
#(
    parameter int STRETCH_CYCLES = 2_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] on_fast_cfg,
    input  logic [CFG_W-1:0] slow_pulse_cfg,
    input  phy_status_t      status,
    input  logic [2:0]       events,
    input  logic             fast_wave,
    input  logic             slow_wave,
    output logic             led_o
);
    localparam int                HOLD_W    = (STRETCH_CYCLES > 1) ? $clog2(STRETCH_CYCLES) : 1;
    localparam logic [HOLD_W-1:0] HOLD_LOAD = HOLD_W'(STRETCH_CYCLES - 1);

    typedef enum logic {PULSE_IDLE, PULSE_HOLD} pulse_state_e;

    pulse_state_e      state_q, state_d;
    logic [HOLD_W-1:0] hold_q, hold_d;
    logic              hit;
    logic              unused_rsv;

    assign hit        = |(slow_pulse_cfg[2:0] & events);
    assign unused_rsv = slow_pulse_cfg[3];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PULSE_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            PULSE_IDLE: if (hit) begin
                state_d = PULSE_HOLD;
                hold_d  = HOLD_LOAD;
            end
            PULSE_HOLD: begin
                if (hit)              hold_d  = HOLD_LOAD;
                else if (hold_q == '0) state_d = PULSE_IDLE;
                else                  hold_d  = hold_q - HOLD_W'(1);
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            PULSE_HOLD: led_o = 1'b0;
            PULSE_IDLE: begin
                if (led_cond(on_fast_cfg[3:0], status))         led_o = fast_wave;
                else if (led_cond(slow_pulse_cfg[7:4], status)) led_o = slow_wave;
                else                                            led_o = led_cond(on_fast_cfg[7:4], status);
            end
        endcase
    end

    // R8: a masked event darkens the lane from the next cycle
    assert_event_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !led_o);
    // R8: an exhausted window without a new event releases the lane
    assert_window_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PULSE_HOLD && hold_q == '0 && !hit) |=> (state_q == PULSE_IDLE));
    // R9: a retrigger restores the full window
    assert_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PULSE_HOLD && hit) |=> (state_q == PULSE_HOLD && hold_q == HOLD_LOAD));
endmodule

// File: rtl/phy_led_ctrl.sv
module phy_led_ctrl
    import phy_led_pkg::*;
#(
    parameter int                CLK_HZ         = 50_000_000,
    parameter int                SIM_TICK       = 0,
    parameter int                STRETCH_CYCLES = 2_000_000,
    parameter int                ADDR_W         = 9,
    parameter logic [ADDR_W-1:0] BASE_ADDR      = 'h1E0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        link_speed,
    input  logic              link_up,
    input  logic              pwr_down,
    input  logic              eee_mode,
    input  logic              aneg_busy,
    input  logic              selftest_busy,
    input  logic              cdiag_busy,
    input  logic              test_mode,
    input  logic              tx_evt,
    input  logic              rx_evt,
    input  logic              col_evt,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic [NUM_LEDS-1:0] led
);
    // 32 base ticks per second give a 16 Hz square wave on the fastest bit.
    localparam int TICK_CYCLES = (SIM_TICK != 0) ? SIM_TICK : (CLK_HZ / 32);

    phy_status_t                     status;
    logic [NUM_REGS-1:0][CFG_W-1:0]  cfg;
    logic                            tick, fast_wave, slow_wave;
    logic                            scan_on, cblink_on;
    logic [NUM_LEDS-1:0]             scan_led, lane_led;
    logic [2:0]                      events;

    assign status = '{speed: link_speed, link_up: link_up, pwr_down: pwr_down,
                      eee: eee_mode, aneg: aneg_busy, selftest: selftest_busy,
                      cdiag: cdiag_busy, test: test_mode};
    assign events = {col_evt, rx_evt, tx_evt};

    phy_led_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_q(cfg)
    );

    phy_led_blink #(.TICK_CYCLES(TICK_CYCLES)) u_blink (
        .clk(clk), .rst_n(rst_n), .fast_code(cfg[0][7:6]), .slow_code(cfg[0][5:4]),
        .tick(tick), .fast_wave(fast_wave), .slow_wave(slow_wave)
    );

    assign scan_on   = cplx_cond(cfg[1][6:4], status) && !cplx_cond(cfg[0][2:0], status);
    assign cblink_on = cplx_cond(cfg[1][2:0], status);

    phy_led_scan u_scan (
        .clk(clk), .rst_n(rst_n), .active(scan_on), .tick(tick), .scan_led(scan_led)
    );

    generate
        for (genvar g = 0; g < NUM_LEDS; g++) begin : g_lane
            phy_led_lane #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .on_fast_cfg(cfg[2 + 2*g]), .slow_pulse_cfg(cfg[3 + 2*g]),
                .status(status), .events(events),
                .fast_wave(fast_wave), .slow_wave(slow_wave), .led_o(lane_led[g])
            );
            assign led[g] = scan_on ? scan_led[g] : (cblink_on ? fast_wave : lane_led[g]);
        end
    endgenerate

    // R11: while scanning, exactly one LED is lit at the pins
    assert_scan_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
        scan_on |-> ($countones(led) == 1));
endmodule

// File: tb/phy_led_ctrl_tb_top.sv
`timescale 1ns/1ps
module phy_led_ctrl_tb_top;
    localparam int TICK = 4;
    localparam int HOLD = 6;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [1:0]  link_speed = 2'd3;
    logic        link_up = 0, pwr_down = 0, eee_mode = 0, aneg_busy = 0;
    logic        selftest_busy = 0, cdiag_busy = 0, test_mode = 0;
    logic        tx_evt = 0, rx_evt = 0, col_evt = 0, reg_we = 0;
    logic [8:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  led;

    phy_led_ctrl #(.SIM_TICK(TICK), .STRETCH_CYCLES(HOLD)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_speed(link_speed), .link_up(link_up),
        .pwr_down(pwr_down), .eee_mode(eee_mode), .aneg_busy(aneg_busy),
        .selftest_busy(selftest_busy), .cdiag_busy(cdiag_busy), .test_mode(test_mode),
        .tx_evt(tx_evt), .rx_evt(rx_evt), .col_evt(col_evt), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .led(led)
    );

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    logic [7:0] sh [10];
    int mpre = 0, mpos = 0;
    logic [3:0] mcnt = '0;
    int mrem [4];

    function automatic logic [7:0] rst_val(input int i);
        logic [7:0] t [10] = '{8'hC5, 8'h67, 8'h70, 8'h03, 8'h20, 8'h00, 8'h40, 8'h00, 8'h40, 8'h20};
        return t[i];
    endfunction

    function automatic logic [7:0] wmask(input int i);
        return (i == 0) ? 8'hF7 : ((i == 1) ? 8'h77 : 8'hFF);
    endfunction

    function automatic logic lcond(input logic [3:0] c);
        logic a, b, d;
        a = link_up && link_speed == 2'd0;
        b = link_up && link_speed == 2'd1;
        d = link_up && link_speed == 2'd2;
        case (c)
            4'h1: return a;           4'h2: return b;
            4'h3: return a | b;       4'h4: return d;
            4'h5: return a | d;       4'h6: return b | d;
            4'h7: return a | b | d;   4'h8: return pwr_down;
            4'h9: return eee_mode;    4'hA: return aneg_busy;
            4'hB: return selftest_busy; 4'hC: return cdiag_busy;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic ccond(input logic [2:0] c);
        logic [7:0] v;
        v = {test_mode, cdiag_busy, selftest_busy, aneg_busy, eee_mode, pwr_down, link_up, 1'b0};
        return v[c];
    endfunction

    function automatic logic scan_act();
        return ccond(sh[1][6:4]) && !ccond(sh[0][2:0]);
    endfunction

    function automatic logic [3:0] exp_led();
        logic [3:0] r;
        logic fw, sw;
        fw = mcnt[3 - int'(sh[0][7:6])];
        sw = mcnt[3 - int'(sh[0][5:4])];
        for (int i = 0; i < 4; i++) begin
            if (scan_act())                r[i] = (mpos == i);
            else if (ccond(sh[1][2:0]))    r[i] = fw;
            else if (mrem[i] != 0)         r[i] = 1'b0;
            else if (lcond(sh[2+2*i][3:0])) r[i] = fw;
            else if (lcond(sh[3+2*i][7:4])) r[i] = sw;
            else                            r[i] = lcond(sh[2+2*i][7:4]);
        end
        return r;
    endfunction

    // Reference model, advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 10; i++) sh[i] <= rst_val(i);
            mpre <= 0; mcnt <= '0; mpos <= 0;
            for (int i = 0; i < 4; i++) mrem[i] <= 0;
        end else begin
            if (reg_we && reg_addr >= 9'h1E0 && reg_addr <= 9'h1E9)
                sh[int'(reg_addr) - 'h1E0] <= reg_wdata[7:0] & wmask(int'(reg_addr) - 'h1E0);
            if (mpre == TICK - 1) begin mpre <= 0; mcnt <= mcnt + 4'd1; end
            else mpre <= mpre + 1;
            if (!scan_act()) mpos <= 0;
            else if (mpre == TICK - 1) mpos <= (mpos + 1) % 4;
            for (int i = 0; i < 4; i++) begin
                if ((sh[3+2*i][2:0] & {col_evt, rx_evt, tx_evt}) != 3'b000) mrem[i] <= HOLD;
                else if (mrem[i] > 0) mrem[i] <= mrem[i] - 1;
            end
        end
    end

    task automatic cmp_led(input string req);
        logic [3:0] e;
        e = exp_led();
        n_cmp++;
        if (led !== e) begin
            n_bad++;
            $display("FAIL %s led act=%b exp=%b at %0t", req, led, e, $time);
        end
    endtask

    task automatic step(input string req);
        @(posedge clk); @(negedge clk);
        #1 cmp_led(req);
    endtask

    task automatic rd(input logic [8:0] a, input logic [15:0] e, input string req);
        reg_addr = a;
        #1;
        n_cmp++;
        if (reg_rdata !== e) begin
            n_bad++;
            $display("FAIL %s rdata[%h] act=%h exp=%h", req, a, reg_rdata, e);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [15:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_st(input logic [1:0] sp, input logic lu, input logic [5:0] f);
        link_speed = sp; link_up = lu;
        {pwr_down, eee_mode, aneg_busy, selftest_busy, cdiag_busy, test_mode} = f;
    endtask

    initial begin
        #3_000_000;
        n_bad++;
        $display("FAIL watchdog run did not finish act=timeout exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] prev;
        void'($urandom(32'd20417));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset contents and dark LEDs
        for (int i = 0; i < 10; i++) rd(9'h1E0 + 9'(i), {8'h00, rst_val(i)}, "R1");
        step("R1");
        // R2: reserved bits masked on write
        wr(9'h1E0, 16'hFFFF); rd(9'h1E0, 16'h00F7, "R2");
        wr(9'h1E1, 16'hFFFF); rd(9'h1E1, 16'h0077, "R2");
        wr(9'h1E3, 16'hABCD); rd(9'h1E3, 16'h00CD, "R2");
        wr(9'h1E0, 16'h00C0); wr(9'h1E1, 16'h0000);
        // R3: unmapped addresses
        wr(9'h1EA, 16'hFFFF); wr(9'h1DF, 16'hFFFF);
        rd(9'h1EA, 16'h0000, "R3"); rd(9'h1DF, 16'h0000, "R3"); rd(9'h000, 16'h0000, "R3");
        for (int i = 0; i < 10; i++) rd(9'h1E0 + 9'(i), {8'h00, sh[i]}, "R3");
        for (int i = 2; i < 10; i++) wr(9'h1E0 + 9'(i), 16'h0000);
        // R4: every selector code against every status pattern
        for (int c = 0; c < 16; c++) begin
            wr(9'h1E2, 16'(c << 4));
            for (int sp = 0; sp < 4; sp++) begin
                set_st(2'(sp), 1'b1, 6'b0); step("R4");
                set_st(2'(sp), 1'b0, 6'b0); step("R4");
            end
            for (int f = 0; f < 6; f++) begin set_st(2'd3, 1'b0, 6'(1 << f)); step("R4"); end
        end
        set_st(2'd1, 1'b1, 6'b0);
        wr(9'h1E2, 16'h0000);
        // R5: fast rates
        wr(9'h1E4, 16'h0007);
        for (int fc = 0; fc < 4; fc++) begin
            wr(9'h1E0, 16'(fc << 6));
            repeat (70) step("R5");
        end
        // R6: slow rates
        wr(9'h1E4, 16'h0000); wr(9'h1E5, 16'h0070);
        for (int sc = 0; sc < 4; sc++) begin
            wr(9'h1E0, 16'(sc << 4));
            repeat (70) step("R6");
        end
        wr(9'h1E5, 16'h0000);
        // R7: priority between fast, slow and steady
        wr(9'h1E0, 16'h00C0);
        wr(9'h1E8, 16'h0077); wr(9'h1E9, 16'h0070); repeat (70) step("R7");
        wr(9'h1E8, 16'h0070); repeat (70) step("R7");
        wr(9'h1E9, 16'h0000); repeat (10) step("R7");
        // R8: masked and unmasked strobes
        wr(9'h1E6, 16'h0070); wr(9'h1E7, 16'h0001);
        tx_evt = 1; step("R8"); tx_evt = 0;
        repeat (10) step("R8");
        rx_evt = 1; step("R8"); rx_evt = 0; step("R8");
        n_cmp++;
        if (led[2] !== 1'b1) begin n_bad++; $display("FAIL R8 unmasked rx act=%b exp=1", led[2]); end
        wr(9'h1E7, 16'h0008);
        tx_evt = 1; rx_evt = 1; col_evt = 1; step("R8");
        tx_evt = 0; rx_evt = 0; col_evt = 0; step("R8");
        wr(9'h1E7, 16'h0004); col_evt = 1; step("R8"); col_evt = 0; repeat (8) step("R8");
        // R9: retrigger inside the window
        wr(9'h1E7, 16'h0007);
        tx_evt = 1; step("R9"); tx_evt = 0;
        repeat (3) step("R9");
        rx_evt = 1; step("R9"); rx_evt = 0;
        repeat (4) step("R9");
        n_cmp++;
        if (led[2] !== 1'b0) begin n_bad++; $display("FAIL R9 extended window act=%b exp=0", led[2]); end
        repeat (4) step("R9");
        // R10: complex blink on test mode
        wr(9'h1E1, 16'h0007); test_mode = 1;
        repeat (40) step("R10");
        test_mode = 0; repeat (5) step("R10");
        // R11: scan on cable diagnostics
        wr(9'h1E1, 16'h0060); cdiag_busy = 1;
        repeat (40) step("R11");
        prev = led;
        repeat (TICK) step("R11");
        n_cmp++;
        if (led !== {prev[2:0], prev[3]}) begin
            n_bad++; $display("FAIL R11 rotate act=%b exp=%b", led, {prev[2:0], prev[3]});
        end
        // R12: inverse condition suppresses the scan
        wr(9'h1E0, 16'h00C6); repeat (20) step("R12");
        cdiag_busy = 0;
        // mixed random traffic with occasional writes
        for (int k = 0; k < 3000; k++) begin
            set_st(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   6'($urandom_range(0, 63) & $urandom_range(0, 63)));
            tx_evt  = ($urandom_range(0, 7) == 0);
            rx_evt  = ($urandom_range(0, 7) == 0);
            col_evt = ($urandom_range(0, 15) == 0);
            if ($urandom_range(0, 15) == 0) begin
                wr(9'h1DE + 9'($urandom_range(0, 13)), 16'($urandom()));
                tx_evt = 0; rx_evt = 0; col_evt = 0;
            end
            step("mixed R4 R7 R8 R11");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule